// File: doc/BRIEF.md
# Streaming YUV to RGB888 Color Converter

This block turns a stream of 8-bit luma/chroma pixels into 8-bit red, green and blue. Each sample first has a programmable offset removed: the luma offset from Y, the chroma offset from Cb and Cr. The centred values are weighted by five unsigned fixed-point coefficients with 10 fractional bits. The sums are rounded and clamped to 0..255. Pixels flagged as RGB skip the arithmetic and leave unchanged, so the output is RGB888 whatever the source format.

Pixels enter and leave through a valid/ready handshake. They pass a three-register pipeline that stalls as a whole when the consumer holds off. A small write port loads a staged copy of the coefficients and offsets. That staged copy becomes active only on a frame-start pulse, so every pixel of one frame sees the same matrix.

Top module: `csc_yuv2rgb`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. The active set is C0=0x4A8, C1=0x662, C2=0x191, C3=0x341, C4=0x811, luma offset 0, chroma offset 128, so the pixel (128,128,128) converts to (149,149,149).
- R2: With y=px0-luma_offset, u=px1-chroma_offset and v=px2-chroma_offset, the channels are R=C0*y+C1*v, G=C0*y-C2*u-C3*v and B=C0*y+C4*u. Each sum has 512 added and is then shifted right arithmetically by 10.
- R3: Each rounded channel is clamped: a negative value gives 0 and a value above 255 gives 255.
- R4: A pixel accepted with in_bypass high leaves with out_r=px0, out_g=px1 and out_b=px2, unchanged.
- R5: With out_ready held high, the result of a pixel accepted in cycle n shows with out_valid high in cycle n+3. Each accepted pixel gives exactly one result, in acceptance order.
- R6: in_ready equals out_ready OR NOT out_valid. While out_valid is high and out_ready is low, the output values hold and no pixel is accepted.
- R7: cfg_we writes the staged set at cfg_addr: 0..4 write C0..C4 from cfg_wdata[11:0], 5 writes the luma offset and 6 writes the chroma offset, both from cfg_wdata[7:0]. A staged value affects only pixels accepted after a cycle with frame_start high.
- R8: The luma offset applies to px0 only and the chroma offset to px1 and px2, as programmed.
- R9: A write to cfg_addr 7 changes no coefficient and no offset.
- R10: A pixel accepted in the same cycle as frame_start uses the set that was active before the pulse. The active set holds between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that moves the staged set into the active set |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration slot select |
| cfg_wdata | input | 12 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_bypass | input | 1 | Pixel is already RGB: pass it through |
| in_px0 | input | 8 | Y (or R when bypassed) |
| in_px1 | input | 8 | Cb (or G when bypassed) |
| in_px2 | input | 8 | Cr (or B when bypassed) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
A wrong active coefficient or offset shows as a wrong colour on the first pixel converted with it, three cycles after that pixel is accepted. A staged write that reaches the active set too early is caught the same way, on pixels sent between the write and the next frame start. A lost or duplicated valid bit in the pipeline shows as a missing, extra or reordered result when the scoreboard is drained. A stall that fails to freeze the output register shows one cycle into the hold.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;

  localparam int NCOEF  = 5;
  localparam int NCH    = 3;
  localparam int CFG_AW = 3;

  localparam int CH_R = 0;
  localparam int CH_G = 1;
  localparam int CH_B = 2;

  localparam int OPD_Y = 0;
  localparam int OPD_U = 1;
  localparam int OPD_V = 2;

  typedef enum logic [CFG_AW-1:0] {
    CFG_C0         = 3'd0,
    CFG_C1         = 3'd1,
    CFG_C2         = 3'd2,
    CFG_C3         = 3'd3,
    CFG_C4         = 3'd4,
    CFG_LUMA_OFS   = 3'd5,
    CFG_CHROMA_OFS = 3'd6,
    CFG_SPARE      = 3'd7
  } cfg_addr_e;

  // which centred sample each coefficient multiplies
  function automatic int coef_operand(input int k);
    case (k)
      0:       return OPD_Y;
      1:       return OPD_V;
      2:       return OPD_U;
      3:       return OPD_V;
      default: return OPD_U;
    endcase
  endfunction

endpackage

// File: rtl/csc_cfg_regs.sv
`timescale 1ns/1ps
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int                          PIX_W      = 8,
  parameter int                          COEF_W     = 12,
  parameter logic [NCOEF-1:0][COEF_W-1:0] DEF_COEFS = '0,
  parameter logic [PIX_W-1:0]            DEF_LUMA   = '0,
  parameter logic [PIX_W-1:0]            DEF_CHROMA = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [COEF_W-1:0]             cfg_wdata,
  input  logic                          frame_start,
  output logic [NCOEF-1:0][COEF_W-1:0]  act_coef,
  output logic [PIX_W-1:0]              act_luma,
  output logic [PIX_W-1:0]              act_chroma
);

  logic [NCOEF-1:0][COEF_W-1:0] stg_coef_q, stg_coef_d;
  logic [NCOEF-1:0][COEF_W-1:0] act_coef_q, act_coef_d;
  logic [PIX_W-1:0]             stg_luma_q, stg_luma_d;
  logic [PIX_W-1:0]             stg_chroma_q, stg_chroma_d;
  logic [PIX_W-1:0]             act_luma_q, act_luma_d;
  logic [PIX_W-1:0]             act_chroma_q, act_chroma_d;

  // staged copy: written by the port at any time
  always_comb begin
    stg_coef_d = stg_coef_q;
    for (int k = 0; k < NCOEF; k++) begin
      if (cfg_we && (cfg_addr == CFG_AW'(k))) begin
        stg_coef_d[k] = cfg_wdata;
      end
    end
    stg_luma_d   = (cfg_we && (cfg_addr == CFG_LUMA_OFS))
                   ? cfg_wdata[PIX_W-1:0] : stg_luma_q;
    stg_chroma_d = (cfg_we && (cfg_addr == CFG_CHROMA_OFS))
                   ? cfg_wdata[PIX_W-1:0] : stg_chroma_q;
  end

  // active copy: moves only on a frame boundary
  always_comb begin
    act_coef_d   = frame_start ? stg_coef_q   : act_coef_q;
    act_luma_d   = frame_start ? stg_luma_q   : act_luma_q;
    act_chroma_d = frame_start ? stg_chroma_q : act_chroma_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_coef_q   <= DEF_COEFS;
      stg_luma_q   <= DEF_LUMA;
      stg_chroma_q <= DEF_CHROMA;
      act_coef_q   <= DEF_COEFS;
      act_luma_q   <= DEF_LUMA;
      act_chroma_q <= DEF_CHROMA;
    end else begin
      stg_coef_q   <= stg_coef_d;
      stg_luma_q   <= stg_luma_d;
      stg_chroma_q <= stg_chroma_d;
      act_coef_q   <= act_coef_d;
      act_luma_q   <= act_luma_d;
      act_chroma_q <= act_chroma_d;
    end
  end

  assign act_coef   = act_coef_q;
  assign act_luma   = act_luma_q;
  assign act_chroma = act_chroma_q;

endmodule

// File: rtl/csc_mult_stage.sv
`timescale 1ns/1ps
module csc_mult_stage
  import csc_pkg::*;
#(
  parameter  int PIX_W  = 8,
  parameter  int COEF_W = 12,
  localparam int DW     = PIX_W + 1,
  localparam int PROD_W = COEF_W + 1 + DW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          in_valid,
  input  logic                          in_bypass,
  input  logic [NCH-1:0][PIX_W-1:0]     in_px,
  input  logic [NCOEF-1:0][COEF_W-1:0]  coef,
  input  logic [PIX_W-1:0]              luma_ofs,
  input  logic [PIX_W-1:0]              chroma_ofs,
  output logic                          s1_valid,
  output logic                          s1_bypass,
  output logic [NCH-1:0][PIX_W-1:0]     s1_px,
  output logic [NCOEF-1:0][PROD_W-1:0]  s1_prod
);

  logic signed [DW-1:0]          dif [NCH];
  logic [NCOEF-1:0][PROD_W-1:0]  prod_d;
  logic                          valid_d;
  logic                          load;

  always_comb begin
    dif[OPD_Y] = $signed({1'b0, in_px[0]}) - $signed({1'b0, luma_ofs});
    dif[OPD_U] = $signed({1'b0, in_px[1]}) - $signed({1'b0, chroma_ofs});
    dif[OPD_V] = $signed({1'b0, in_px[2]}) - $signed({1'b0, chroma_ofs});
  end

  // products use the active set at acceptance time
  for (genvar k = 0; k < NCOEF; k++) begin : g_prod
    localparam int OPD = coef_operand(k);
    assign prod_d[k] = PROD_W'($signed({1'b0, coef[k]})) * PROD_W'(dif[OPD]);
  end

  assign load    = en && in_valid;
  assign valid_d = en ? in_valid : s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      s1_bypass <= in_bypass;
      s1_px     <= in_px;
      s1_prod   <= prod_d;
    end
  end

endmodule

// File: rtl/csc_sum_stage.sv
`timescale 1ns/1ps
module csc_sum_stage
  import csc_pkg::*;
#(
  parameter  int PIX_W  = 8,
  parameter  int COEF_W = 12,
  parameter  int FRAC_W = 10,
  localparam int PROD_W = COEF_W + PIX_W + 2,
  localparam int SUM_W  = PROD_W + 2,
  localparam int SH_W   = SUM_W - FRAC_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          s1_valid,
  input  logic                          s1_bypass,
  input  logic [NCH-1:0][PIX_W-1:0]     s1_px,
  input  logic [NCOEF-1:0][PROD_W-1:0]  s1_prod,
  output logic                          s2_valid,
  output logic                          s2_bypass,
  output logic [NCH-1:0][PIX_W-1:0]     s2_px,
  output logic [NCH-1:0][SH_W-1:0]      s2_ch
);

  localparam int RND = 1 << (FRAC_W - 1);

  logic signed [SUM_W-1:0]  pe  [NCOEF];
  logic signed [SUM_W-1:0]  acc [NCH];
  logic [NCH-1:0][SH_W-1:0] ch_d;
  logic                     valid_d;
  logic                     load;

  for (genvar k = 0; k < NCOEF; k++) begin : g_ext
    assign pe[k] = SUM_W'($signed(s1_prod[k]));
  end

  always_comb begin
    acc[CH_R] = pe[0] + pe[1];
    acc[CH_G] = pe[0] - pe[2] - pe[3];
    acc[CH_B] = pe[0] + pe[4];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rnd
    logic signed [SUM_W-1:0] rnd;
    assign rnd     = acc[c] + SUM_W'(RND);
    assign ch_d[c] = SH_W'(rnd >>> FRAC_W);
  end

  assign load    = en && s1_valid;
  assign valid_d = en ? s1_valid : s2_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      s2_bypass <= s1_bypass;
      s2_px     <= s1_px;
      s2_ch     <= ch_d;
    end
  end

endmodule

// File: rtl/csc_sat_stage.sv
`timescale 1ns/1ps
module csc_sat_stage
  import csc_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SH_W  = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      s2_valid,
  input  logic                      s2_bypass,
  input  logic [NCH-1:0][PIX_W-1:0] s2_px,
  input  logic [NCH-1:0][SH_W-1:0]  s2_ch,
  output logic                      s3_valid,
  output logic [NCH-1:0][PIX_W-1:0] s3_px
);

  localparam int MAXV = (1 << PIX_W) - 1;

  logic [NCH-1:0][PIX_W-1:0] px_d;
  logic                      valid_d;
  logic                      load;

  for (genvar c = 0; c < NCH; c++) begin : g_clamp
    logic signed [SH_W-1:0] v;
    logic [PIX_W-1:0]       sat;
    assign v = $signed(s2_ch[c]);
    always_comb begin
      if (v < 0) begin
        sat = '0;
      end else if (v > SH_W'(MAXV)) begin
        sat = PIX_W'(MAXV);
      end else begin
        sat = v[PIX_W-1:0];
      end
    end
    assign px_d[c] = s2_bypass ? s2_px[c] : sat;
  end

  assign load    = en && s2_valid;
  assign valid_d = en ? s2_valid : s3_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid <= 1'b0;
    end else begin
      s3_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      s3_px <= px_d;
    end
  end

endmodule

// File: rtl/csc_yuv2rgb.sv
`timescale 1ns/1ps
module csc_yuv2rgb
  import csc_pkg::*;
#(
  parameter int               PIX_W      = 8,
  parameter int               COEF_W     = 12,
  parameter int               FRAC_W     = 10,
  parameter logic [COEF_W-1:0] DEF_C0    = 12'h4A8,
  parameter logic [COEF_W-1:0] DEF_C1    = 12'h662,
  parameter logic [COEF_W-1:0] DEF_C2    = 12'h191,
  parameter logic [COEF_W-1:0] DEF_C3    = 12'h341,
  parameter logic [COEF_W-1:0] DEF_C4    = 12'h811,
  parameter logic [PIX_W-1:0]  DEF_LUMA  = 8'd0,
  parameter logic [PIX_W-1:0]  DEF_CHROMA = 8'd128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bypass,
  input  logic [PIX_W-1:0]  in_px0,
  input  logic [PIX_W-1:0]  in_px1,
  input  logic [PIX_W-1:0]  in_px2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);

  localparam int PROD_W = COEF_W + PIX_W + 2;
  localparam int SUM_W  = PROD_W + 2;
  localparam int SH_W   = SUM_W - FRAC_W;
  localparam int ACT_W  = NCOEF * COEF_W + 2 * PIX_W;
  localparam logic [NCOEF-1:0][COEF_W-1:0] DEF_COEFS =
    {DEF_C4, DEF_C3, DEF_C2, DEF_C1, DEF_C0};

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  logic [NCOEF-1:0][COEF_W-1:0] act_coef;
  logic [PIX_W-1:0]             act_luma, act_chroma;
  logic [ACT_W-1:0]             act_flat;

  logic                         pipe_en;
  logic [NCH-1:0][PIX_W-1:0]    in_px;

  logic                         s1_valid, s1_bypass;
  logic [NCH-1:0][PIX_W-1:0]    s1_px;
  logic [NCOEF-1:0][PROD_W-1:0] s1_prod;

  logic                         s2_valid, s2_bypass;
  logic [NCH-1:0][PIX_W-1:0]    s2_px;
  logic [NCH-1:0][SH_W-1:0]     s2_ch;

  logic                         s3_valid;
  logic [NCH-1:0][PIX_W-1:0]    s3_px;

  // whole pipe advances unless the output is held
  assign pipe_en  = out_ready || !s3_valid;
  assign in_ready = pipe_en;
  assign in_px    = {in_px2, in_px1, in_px0};
  assign act_flat = {act_coef, act_luma, act_chroma};

  csc_cfg_regs #(
    .PIX_W      (PIX_W),
    .COEF_W     (COEF_W),
    .DEF_COEFS  (DEF_COEFS),
    .DEF_LUMA   (DEF_LUMA),
    .DEF_CHROMA (DEF_CHROMA)
  ) cfg_i (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .frame_start (frame_start),
    .act_coef    (act_coef),
    .act_luma    (act_luma),
    .act_chroma  (act_chroma)
  );

  csc_mult_stage #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W)
  ) mult_i (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .en         (pipe_en),
    .in_valid   (in_valid),
    .in_bypass  (in_bypass),
    .in_px      (in_px),
    .coef       (act_coef),
    .luma_ofs   (act_luma),
    .chroma_ofs (act_chroma),
    .s1_valid   (s1_valid),
    .s1_bypass  (s1_bypass),
    .s1_px      (s1_px),
    .s1_prod    (s1_prod)
  );

  csc_sum_stage #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W)
  ) sum_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en        (pipe_en),
    .s1_valid  (s1_valid),
    .s1_bypass (s1_bypass),
    .s1_px     (s1_px),
    .s1_prod   (s1_prod),
    .s2_valid  (s2_valid),
    .s2_bypass (s2_bypass),
    .s2_px     (s2_px),
    .s2_ch     (s2_ch)
  );

  csc_sat_stage #(
    .PIX_W (PIX_W),
    .SH_W  (SH_W)
  ) sat_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .en        (pipe_en),
    .s2_valid  (s2_valid),
    .s2_bypass (s2_bypass),
    .s2_px     (s2_px),
    .s2_ch     (s2_ch),
    .s3_valid  (s3_valid),
    .s3_px     (s3_px)
  );

  assign out_valid = s3_valid;
  assign out_r     = s3_px[CH_R];
  assign out_g     = s3_px[CH_G];
  assign out_b     = s3_px[CH_B];

endmodule

// File: rtl/csc_yuv2rgb_chk.sv
`timescale 1ns/1ps
module csc_yuv2rgb_chk #(
  parameter int PIX_W = 8,
  parameter int ACT_W = 76
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b,
  input logic [ACT_W-1:0] act_cfg
);

  logic [3*PIX_W-1:0] out_rgb;
  assign out_rgb = {out_r, out_g, out_b};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      idle_in_reset_chk: assert (!out_valid);
    end
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));

endmodule

bind csc_yuv2rgb csc_yuv2rgb_chk #(
  .PIX_W (PIX_W),
  .ACT_W (ACT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_r       (out_r),
  .out_g       (out_g),
  .out_b       (out_b),
  .act_cfg     (act_flat)
);

// File: tb/csc_yuv2rgb_tb_top.sv
`timescale 1ns/1ps
module csc_yuv2rgb_tb_top;

  localparam int PIX_W  = 8;
  localparam int COEF_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_start = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [COEF_W-1:0] cfg_wdata = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_bypass = 1'b0;
  logic [PIX_W-1:0]  in_px0 = '0, in_px1 = '0, in_px2 = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [PIX_W-1:0]  out_r, out_g, out_b;

  always #4 clk = ~clk;

  csc_yuv2rgb dut_i (
    .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
    .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .in_valid (in_valid), .in_ready (in_ready), .in_bypass (in_bypass),
    .in_px0 (in_px0), .in_px1 (in_px1), .in_px2 (in_px2),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_r (out_r), .out_g (out_g), .out_b (out_b)
  );

  // staged stimulus, applied at the falling edge
  logic              d_valid = 0, d_bypass = 0, d_ready = 1, d_fs = 0, d_we = 0;
  logic [2:0]        d_addr = '0;
  logic [COEF_W-1:0] d_wdata = '0;
  logic [PIX_W-1:0]  d_p0 = '0, d_p1 = '0, d_p2 = '0;

  int n_chk = 0;
  int n_bad = 0;
  int m_stg [7];
  int m_act [7];
  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic        prev_stall = 1'b0;
  logic [23:0] prev_out = '0;
  logic [23:0] last_out = '0;
  logic        ov_s = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] clamp8(input int s);
    int t;
    t = (s + 512) >>> 10;
    if (t < 0) return 8'd0;
    if (t > 255) return 8'd255;
    return t[7:0];
  endfunction

  function automatic logic [23:0] model_rgb(input int p0, input int p1, input int p2,
                                            input bit byp);
    int y, u, v;
    if (byp) return {p0[7:0], p1[7:0], p2[7:0]};
    y = p0 - m_act[5];
    u = p1 - m_act[6];
    v = p2 - m_act[6];
    return {clamp8(m_act[0]*y + m_act[1]*v),
            clamp8(m_act[0]*y - m_act[2]*u - m_act[3]*v),
            clamp8(m_act[0]*y + m_act[4]*u)};
  endfunction

  task automatic tick(input string tag);
    logic [23:0] got, e;
    string t;
    @(negedge clk);
    in_valid = d_valid; in_bypass = d_bypass; out_ready = d_ready;
    frame_start = d_fs; cfg_we = d_we; cfg_addr = d_addr; cfg_wdata = d_wdata;
    in_px0 = d_p0; in_px1 = d_p1; in_px2 = d_p2;
    #3;
    got = {out_r, out_g, out_b};
    ov_s = out_valid;
    if (prev_stall) begin
      // R6 output held during stall
      check(out_valid && (got == prev_out), "R6", "held output", got, prev_out);
    end
    if (out_valid && !out_ready) begin
      // R6 no acceptance while held
      check(!in_ready, "R6", "in_ready during stall", in_ready, 0);
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model_rgb(in_px0, in_px1, in_px2, in_bypass));
      tag_q.push_back(in_bypass ? "R4" : tag);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "result without pixel", got, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, t, "pixel", got, e);
      end
      last_out = got;
    end
    prev_stall = out_valid && !out_ready;
    prev_out   = got;
    if (frame_start) m_act = m_stg;
    if (cfg_we && cfg_addr < 3'd5) m_stg[cfg_addr] = int'(cfg_wdata);
    else if (cfg_we && cfg_addr < 3'd7) m_stg[cfg_addr] = int'(cfg_wdata[7:0]);
  endtask

  task automatic drain();
    d_valid = 0; d_ready = 1; d_fs = 0; d_we = 0;
    for (int i = 0; i < 30 && (exp_q.size() != 0 || ov_s); i++) tick("");
  endtask

  task automatic send(input int p0, input int p1, input int p2, input bit byp,
                      input string tag);
    d_p0 = p0[7:0]; d_p1 = p1[7:0]; d_p2 = p2[7:0]; d_bypass = byp;
    d_valid = 1; d_ready = 1;
    tick(tag);
    d_valid = 0; d_fs = 0; d_we = 0;
  endtask

  task automatic cfg_write(input int a, input int v);
    d_we = 1; d_addr = a[2:0]; d_wdata = v[COEF_W-1:0];
    tick("");
    d_we = 0;
  endtask

  task automatic pulse_frame();
    d_fs = 1;
    tick("");
    d_fs = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_stg = '{1192, 1634, 401, 833, 2065, 0, 128};
    m_act = m_stg;
    void'($urandom(32'd20240611));

    repeat (3) tick("");
    check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) tick("");
    check(in_ready && !out_valid, "R1", "idle after reset",
          {in_ready, out_valid}, 2'b10);

    // R1 defaults
    send(128, 128, 128, 0, "R1"); drain();
    check(last_out == 24'h959595, "R1", "default matrix", last_out, 24'h959595);

    // R5 latency
    d_p0 = 8'd50; d_p1 = 8'd90; d_p2 = 8'd200; d_bypass = 0; d_valid = 1;
    tick("R5");
    d_valid = 0;
    tick(""); check(!ov_s, "R5", "valid early (1)", ov_s, 0);
    tick(""); check(!ov_s, "R5", "valid early (2)", ov_s, 0);
    tick(""); check(ov_s, "R5", "valid at third cycle", ov_s, 1);
    drain();

    // R3 saturation
    send(255, 128, 128, 0, "R3"); drain();
    check(last_out == 24'hFFFFFF, "R3", "clamp high", last_out, 24'hFFFFFF);
    send(0, 128, 0, 0, "R3"); drain();
    check(last_out == 24'h006800, "R3", "clamp low", last_out, 24'h006800);
    send(235, 255, 0, 0, "R3"); send(16, 0, 255, 0, "R3"); drain();

    // R4 bypass
    send(12, 200, 77, 1, "R4"); drain();
    check(last_out == 24'h0CC84D, "R4", "bypass", last_out, 24'h0CC84D);

    // R7 staged write waits for frame start
    cfg_write(0, 12'h400);
    send(128, 128, 128, 0, "R7"); drain();
    check(last_out == 24'h959595, "R7", "staged not active", last_out, 24'h959595);
    pulse_frame();
    send(100, 128, 128, 0, "R7"); drain();
    check(last_out == 24'h646464, "R7", "active after frame", last_out, 24'h646464);

    // R10 pixel in the frame-start cycle keeps the old set
    cfg_write(0, 12'h200);
    d_fs = 1;
    send(100, 128, 128, 0, "R10"); drain();
    check(last_out == 24'h646464, "R10", "same-cycle pixel", last_out, 24'h646464);
    send(100, 128, 128, 0, "R10"); drain();
    check(last_out == 24'h323232, "R10", "next pixel", last_out, 24'h323232);

    // R8 offsets
    cfg_write(0, 12'h4A8);
    cfg_write(5, 16);
    pulse_frame();
    send(16, 128, 128, 0, "R8"); drain();
    check(last_out == 24'h000000, "R8", "luma offset zero", last_out, 24'h0);
    send(116, 128, 128, 0, "R8"); drain();
    check(last_out == 24'h747474, "R8", "luma offset", last_out, 24'h747474);
    cfg_write(6, 100);
    pulse_frame();
    send(16, 100, 100, 0, "R8"); drain();
    check(last_out == 24'h000000, "R8", "chroma offset", last_out, 24'h0);
    cfg_write(6, 128);

    // R9 spare slot
    cfg_write(7, 12'hFFF);
    pulse_frame();
    send(116, 128, 128, 0, "R9"); drain();
    check(last_out == 24'h747474, "R9", "spare write ignored", last_out, 24'h747474);

    // R2 random stream with backpressure and reconfiguration
    for (int i = 0; i < 4000; i++) begin
      d_valid  = ($urandom % 4) != 0;
      d_ready  = ($urandom % 4) != 0;
      d_bypass = ($urandom % 5) == 0;
      d_p0 = ($urandom % 8 == 0) ? 8'd255 : 8'($urandom);
      d_p1 = ($urandom % 8 == 0) ? 8'd0   : 8'($urandom);
      d_p2 = 8'($urandom);
      d_we = ($urandom % 40) == 0;
      d_addr = 3'($urandom);
      d_wdata = (d_addr < 3'd5) ? 12'($urandom) : 12'($urandom % 256);
      d_fs = ($urandom % 50) == 0;
      tick("R2");
    end
    drain();
    check(exp_q.size() == 0, "R5", "every pixel returned", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule